// File: doc/BRIEF.md
# S/PDIF Channel-Status Block Shifter

This block feeds the channel-status bit of an S/PDIF transmitter. A block of channel status is 192 bits, one per audio frame, and is held in a page of six 32-bit words. The shifter walks through the page one bit per frame. It sends the least significant bit of each word first and takes the words in order from the first to the sixth. After the sixth word it starts again at the first. The frame encoder reads `statusBit` and places the same value in both subframes of the current frame.

The encoder gives two inputs: a one-cycle `frameStrobe` at the start of every frame, and `blockStart` during the strobe of the frame that carries the block-start preamble. A block-start frame always restarts the page at bit 0 of the first word. The shifter moves only on frame strobes, and it only begins once it has seen a block start. `busy` marks the part of the block from the loading of the first word up to the loading of the last word. It also drops at the first frame boundary after the transmitter is switched off.

Top module: `cs_tx_shifter`

## Requirements
- R1: After reset, `statusBit` and `busy` are both 0.
- R2: A frame strobe with `blockStart` high, while `txEnable` and `statusEnable` are both high, loads the first word (page bits [31:0]). From the next cycle `statusBit` shows page bit 0 and `busy` is 1.
- R3: Word k sits in page bits [32k+31:32k]. The frame n frames after a block-start frame (n from 0 to 191) shows page bit n, so bits go LSB first within a word and words go first to sixth.
- R4: The next word is loaded at the frame strobe that follows the frame carrying bit 31 of the current word. After the sixth word, frame 192 shows page bit 0 again without any `blockStart`, and `busy` returns to 1.
- R5: `busy` drops at the frame strobe that loads the sixth word (frame 160) and stays 0 for frames 160 to 191.
- R6: At a frame strobe where `txEnable` or `statusEnable` is low, `busy` is cleared. Between strobes a dropped `txEnable` leaves `busy` unchanged.
- R7: `statusBit` is 0 in any cycle where `txEnable` or `statusEnable` is low, with no wait for a frame boundary.
- R8: A disabled frame strobe resets the bit and word positions. After re-enabling, `statusBit` stays 0 and `busy` stays 0 until a block-start frame, which restarts at page bit 0.
- R9: `blockStart` wins over the word-boundary advance. Any block-start frame shows page bit 0, and the frames after it continue from page bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pageWords | input | 192 | Six 32-bit channel-status words; word k in bits [32k+31:32k] |
| txEnable | input | 1 | Transmitter enable |
| statusEnable | input | 1 | Channel-status transmission enable |
| frameStrobe | input | 1 | One-cycle pulse at the start of each frame |
| blockStart | input | 1 | High with the strobe of the block-start frame |
| statusBit | output | 1 | Channel-status bit for the current frame |
| busy | output | 1 | Channel-status shifting in progress |

## Verification
Two things can fall in the same frame strobe: a block-start realignment and the advance to the next word after bit 31 has been sent. The bench provokes this by sending 32 frames of the first word and then raising `blockStart` on the strobe where the second word would otherwise load. The first and second words are chosen so that their bit 0 values differ. The result is judged by `statusBit` showing the first word's bit 0 and not the second word's, and by the following frame continuing with page bit 1.

// File: rtl/cs_shift_pkg.sv
package cs_shift_pkg;
  parameter int CS_WORD_BITS = 32;
  parameter int CS_NUM_WORDS = 6;
  localparam int CS_BIT_W = $clog2(CS_WORD_BITS);
  localparam int CS_WORD_SEL_W = $clog2(CS_NUM_WORDS);
  localparam int CS_PAGE_BITS = CS_WORD_BITS * CS_NUM_WORDS;

  // Strobes from sequencer to datapath, valid for one cycle
  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
    logic [CS_WORD_SEL_W-1:0] wordSel;
  } csStrobe_t;
endpackage

// File: rtl/cs_shift_ctrl.sv
module cs_shift_ctrl
  import cs_shift_pkg::*;
#(
  parameter int WORD_BITS = CS_WORD_BITS,
  parameter int NUM_WORDS = CS_NUM_WORDS
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      statusEnable,
  input  logic      frameStrobe,
  input  logic      blockStart,
  output csStrobe_t strobes,
  output logic      busy
);
  localparam int BIT_W = $clog2(WORD_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);
  localparam logic [CS_WORD_SEL_W-1:0] LAST_WORD = CS_WORD_SEL_W'(NUM_WORDS - 1);

  logic [BIT_W-1:0] bitIdx;
  logic [CS_WORD_SEL_W-1:0] wordIdx;
  logic [CS_WORD_SEL_W-1:0] nextWord;
  logic synced;
  logic active;
  logic atLastBit;

  assign active    = txEnable && statusEnable;
  assign atLastBit = (bitIdx == LAST_BIT);
  assign nextWord  = (wordIdx == LAST_WORD) ? '0 : wordIdx + 1'b1;

  always_comb begin
    strobes = '0;
    if (frameStrobe) begin
      if (!active) begin
        strobes.clear = 1'b1;
      end else if (blockStart) begin
        strobes.load = 1'b1;
        strobes.wordSel = '0;
      end else if (synced) begin
        if (atLastBit) begin
          strobes.load = 1'b1;
          strobes.wordSel = nextWord;
        end else begin
          strobes.shift = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      wordIdx <= '0;
      synced  <= 1'b0;
      busy    <= 1'b0;
    end else if (frameStrobe) begin
      if (!active) begin
        bitIdx  <= '0;
        wordIdx <= '0;
        synced  <= 1'b0;
        busy    <= 1'b0;
      end else if (blockStart) begin
        bitIdx  <= '0;
        wordIdx <= '0;
        synced  <= 1'b1;
        busy    <= 1'b1;
      end else if (synced) begin
        if (atLastBit) begin
          bitIdx  <= '0;
          wordIdx <= nextWord;
          if (nextWord == '0) busy <= 1'b1;
          else if (nextWord == LAST_WORD) busy <= 1'b0;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && active && blockStart |=> busy);

  a_r5_busy_off_last_word: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && active && !blockStart && synced && atLastBit
      && (wordIdx == LAST_WORD - 1'b1) |=> !busy);

  a_r6_busy_off_disabled: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && !txEnable |=> !busy);

  a_r6_busy_holds_between: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(busy));
endmodule

// File: rtl/cs_shift_datapath.sv
module cs_shift_datapath
  import cs_shift_pkg::*;
#(
  parameter int WORD_BITS = CS_WORD_BITS,
  parameter int NUM_WORDS = CS_NUM_WORDS
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [WORD_BITS*NUM_WORDS-1:0] pageWords,
  input  csStrobe_t                      strobes,
  output logic                           curBit
);
  logic [WORD_BITS-1:0] words [NUM_WORDS];
  logic [WORD_BITS-1:0] shiftReg;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign words[k] = pageWords[k*WORD_BITS +: WORD_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.clear) begin
      shiftReg <= '0;
    end else if (strobes.load) begin
      shiftReg <= words[strobes.wordSel];
    end else if (strobes.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign curBit = shiftReg[0];
endmodule

// File: rtl/cs_tx_shifter.sv
module cs_tx_shifter
  import cs_shift_pkg::*;
#(
  parameter int WORD_BITS = CS_WORD_BITS,
  parameter int NUM_WORDS = CS_NUM_WORDS
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [WORD_BITS*NUM_WORDS-1:0] pageWords,
  input  logic                           txEnable,
  input  logic                           statusEnable,
  input  logic                           frameStrobe,
  input  logic                           blockStart,
  output logic                           statusBit,
  output logic                           busy
);
  csStrobe_t strobes;
  logic curBit;

  cs_shift_ctrl #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .statusEnable(statusEnable),
    .frameStrobe(frameStrobe), .blockStart(blockStart),
    .strobes(strobes), .busy(busy)
  );

  cs_shift_datapath #(.WORD_BITS(WORD_BITS), .NUM_WORDS(NUM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .pageWords(pageWords),
    .strobes(strobes), .curBit(curBit)
  );

  assign statusBit = curBit && txEnable && statusEnable;

  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && txEnable && statusEnable && blockStart
      |=> (!(txEnable && statusEnable) || statusBit == $past(pageWords[0])));
endmodule

// File: tb/sim_cs_tx_shifter.sv
module sim_cs_tx_shifter;
  localparam int PAGE = 192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PAGE-1:0] pageWords = '0;
  logic txEnable = 1'b0;
  logic statusEnable = 1'b0;
  logic frameStrobe = 1'b0;
  logic blockStart = 1'b0;
  logic statusBit;
  logic busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_tx_shifter u0 (
    .clk(clk), .rstN(rstN), .pageWords(pageWords), .txEnable(txEnable),
    .statusEnable(statusEnable), .frameStrobe(frameStrobe),
    .blockStart(blockStart), .statusBit(statusBit), .busy(busy)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frame(logic bs);
    @(negedge clk);
    frameStrobe = 1'b1;
    blockStart = bs;
    @(negedge clk);
    frameStrobe = 1'b0;
    blockStart = 1'b0;
  endtask

  task automatic testReset();
    check("R1 statusBit", statusBit, 1'b0);
    check("R1 busy", busy, 1'b0);
  endtask

  // R2 R3 R4 R5: one full block plus the wrap frame
  task automatic testFullBlock(logic [PAGE-1:0] pg);
    pageWords = pg;
    txEnable = 1'b1;
    statusEnable = 1'b1;
    for (int n = 0; n < PAGE; n++) begin
      frame(n == 0);
      check(n == 0 ? "R2 bit" : "R3 bit", statusBit, pg[n]);
      check(n < 160 ? "R2 busy" : "R5 busy", busy, n < 160);
    end
    frame(1'b0);
    check("R4 wrap bit", statusBit, pg[0]);
    check("R4 wrap busy", busy, 1'b1);
  endtask

  task automatic testTxDrop();
    @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    check("R7 tx off bit", statusBit, 1'b0);
    check("R6 busy held", busy, 1'b1);
    frame(1'b0);
    check("R6 busy cleared", busy, 1'b0);
  endtask

  task automatic testResync();
    txEnable = 1'b1;
    for (int n = 0; n < 3; n++) begin
      frame(1'b0);
      check("R8 unsynced bit", statusBit, 1'b0);
      check("R8 unsynced busy", busy, 1'b0);
    end
    frame(1'b1);
    check("R8 restart bit", statusBit, pageWords[0]);
    check("R8 restart busy", busy, 1'b1);
  endtask

  // R9: block start on the frame where word B would load
  task automatic testPriority();
    for (int n = 1; n < 32; n++) begin
      frame(1'b0);
      check("R3 bit", statusBit, pageWords[n]);
    end
    frame(1'b1);
    check("R9 realign bit", statusBit, pageWords[0]);
    check("R9 busy", busy, 1'b1);
    frame(1'b0);
    check("R9 next bit", statusBit, pageWords[1]);
    frame(1'b1);
    check("R9 second realign", statusBit, pageWords[0]);
  endtask

  task automatic testStatusOff();
    @(negedge clk);
    statusEnable = 1'b0;
    @(negedge clk);
    check("R7 cs off bit", statusBit, 1'b0);
    check("R6 busy held", busy, 1'b1);
    frame(1'b0);
    check("R6 cs off busy", busy, 1'b0);
    statusEnable = 1'b1;
    frame(1'b0);
    check("R8 after cs off", statusBit, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullBlock({32'h5A5A_1234, 32'h8001_7FFE, 32'h0123_4567,
                   32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'hC3A5_5A3D});
    testTxDrop();
    testFullBlock({32'hA5A5_EDCB, 32'h7FFE_8001, 32'hFEDC_BA98,
                   32'h2152_4110, 32'h0F0F_F0F0, 32'hC3A5_5A3D});
    testTxDrop();
    testResync();
    testPriority();
    testStatusOff();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule